// File: doc/BRIEF.md
# Single-Slope ADC Gray Latch Array

This block is the digital back end of a pixel-parallel single-slope converter. One shared counter steps through 256 ramp positions, one per clock, while a conversion runs. Its binary value leaves the block on `ramp_code_o` so that an external DAC can build the ramp. Its Gray-coded form is broadcast to every pixel cell. Consecutive Gray codes differ in a single bit, so a pixel that stops sampling the broadcast at an awkward moment can be off by at most one step. It never picks up a mixture of two codes.

Each pixel owns an 8-bit memory. The memory follows the broadcast code while that pixel's comparator stays low. A two-flop synchronizer sits between each comparator and its cell. Once the synchronized comparator reads high, the memory freezes, and it stays frozen until the next conversion starts. After `done_o` rises, software-free readout logic selects one pixel by address and turns its stored Gray code back into binary.

Top module: `ssadc_latch_array`

## Requirements
- R1: After reset `busy_o`, `done_o` and `ramp_code_o` are 0, and every pixel reads back 0.
- R2: A `start_i` pulse while idle makes `busy_o` 1 and `ramp_code_o` 0 on the next cycle, and clears `done_o`.
- R3: While busy, `ramp_code_o` rises by one per clock from 0 to 255. At the clock edge that ends step 255, `busy_o` falls and `done_o` rises. `done_o` stays high until the next accepted start.
- R4: The broadcast code equals the Gray form of the ramp value (g = b XOR (b >> 1)). During a conversion it changes in exactly one bit per step.
- R5: A comparator that first reads high at the edge that ends ramp step e stores the code for step e+1, which is two synchronizer stages after the rise. The stored value saturates at 255.
- R6: A pixel whose comparator stays low for the whole conversion reads 255.
- R7: A comparator already high for at least two clocks before the accepted start reads 0.
- R8: After a pixel freezes, later toggles of its comparator do not change its stored code until the next start.
- R9: A `start_i` pulse while busy is ignored: the ramp keeps counting and nothing restarts.
- R10: `rd_data_o` is the binary decode of the addressed pixel's code, with b[7]=g[7] and b[i]=b[i+1] XOR g[i] going down. The path is combinational. Addresses at or above N_PIX read 0.
- R11: Pixels convert independently: different flip times in one conversion give different, individually correct codes.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock, one ramp step per cycle |
| rst_ni | input | 1 | Active-low synchronous reset |
| start_i | input | 1 | Conversion start pulse |
| cmp_i | input | N_PIX | Asynchronous comparator output per pixel, high once ramp passes pixel level |
| rd_addr_i | input | ADDR_W | Pixel readout address |
| rd_data_o | output | 8 | Binary code of addressed pixel |
| ramp_code_o | output | 8 | Current binary ramp step for the ramp DAC |
| busy_o | output | 1 | Conversion running |
| done_o | output | 1 | Conversion finished, codes valid |

## Verification
The cases that need care are those where a pixel's freeze falls in the same cycle as the end of the ramp. Comparator rises placed just before the edges that end steps 254 and 255 must both give 255, so the bench drives exactly those steps. They are judged against the rise-plus-one rule with saturation, and checked alongside the fall of `busy_o`. A second collision is a start pulse arriving during a running conversion. A per-clock reference model of busy, done and ramp value catches any restart.

// File: rtl/ssadc_pkg.sv
package ssadc_pkg;
  parameter int CODE_W = 8;
  localparam int CODE_MAX = (1 << CODE_W) - 1;

  typedef logic [CODE_W-1:0] code_t;

  function automatic code_t bin2gray(input code_t b);
    return b ^ (b >> 1);
  endfunction

  function automatic code_t gray2bin(input code_t g);
    code_t b;
    b[CODE_W-1] = g[CODE_W-1];
    for (int i = CODE_W - 2; i >= 0; i--) begin
      b[i] = b[i+1] ^ g[i];
    end
    return b;
  endfunction
endpackage

// File: rtl/ssadc_ramp_ctr.sv
module ssadc_ramp_ctr
  import ssadc_pkg::*;
(
  input  logic  clk_i,
  input  logic  rst_ni,
  input  logic  start_i,
  output logic  start_acc_o,
  output logic  busy_o,
  output logic  done_o,
  output code_t ramp_bin_o,
  output code_t ramp_gray_o
);
  logic  busy_q, done_q;
  code_t cnt_q;
  logic  last_step;

  assign start_acc_o = start_i & ~busy_q;
  assign last_step   = (cnt_q == code_t'(CODE_MAX));

  always_ff @(posedge clk_i) begin
    if (!rst_ni) begin
      busy_q <= 1'b0;
      done_q <= 1'b0;
      cnt_q  <= '0;
    end else if (start_acc_o) begin
      busy_q <= 1'b1;
      done_q <= 1'b0;
      cnt_q  <= '0;
    end else if (busy_q) begin
      if (last_step) begin
        busy_q <= 1'b0;
        done_q <= 1'b1;
      end else begin
        cnt_q <= cnt_q + code_t'(1);
      end
    end
  end

  assign busy_o      = busy_q;
  assign done_o      = done_q;
  assign ramp_bin_o  = cnt_q;
  assign ramp_gray_o = bin2gray(cnt_q);
endmodule

// File: rtl/ssadc_cmp_sync.sv
module ssadc_cmp_sync #(
  parameter int N_PIX  = 5,
  parameter int STAGES = 2
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [N_PIX-1:0] async_i,
  output logic [N_PIX-1:0] sync_o
);
  logic [N_PIX-1:0] stage_q [STAGES];

  always_ff @(posedge clk_i) begin
    if (!rst_ni) begin
      for (int s = 0; s < STAGES; s++) stage_q[s] <= '0;
    end else begin
      stage_q[0] <= async_i;
      for (int s = 1; s < STAGES; s++) stage_q[s] <= stage_q[s-1];
    end
  end

  assign sync_o = stage_q[STAGES-1];
endmodule

// File: rtl/ssadc_pix_cell.sv
module ssadc_pix_cell
  import ssadc_pkg::*;
(
  input  logic  clk_i,
  input  logic  rst_ni,
  input  logic  clear_i,
  input  logic  step_i,
  input  logic  hit_i,
  input  code_t code_i,
  output logic  load_o,
  output code_t code_o
);
  logic  armed_q;
  code_t mem_q;

  assign load_o = step_i & armed_q & ~hit_i;

  always_ff @(posedge clk_i) begin
    if (!rst_ni) begin
      armed_q <= 1'b0;
      mem_q   <= '0;
    end else if (clear_i) begin
      armed_q <= 1'b1;
      mem_q   <= '0;
    end else begin
      if (load_o) mem_q <= code_i;
      if (step_i && hit_i) armed_q <= 1'b0;
    end
  end

  assign code_o = mem_q;
endmodule

// File: rtl/ssadc_readout.sv
module ssadc_readout
  import ssadc_pkg::*;
#(
  parameter int N_PIX  = 5,
  parameter int ADDR_W = 3
) (
  input  logic [N_PIX-1:0][CODE_W-1:0] codes_i,
  input  logic [ADDR_W-1:0]            addr_i,
  output code_t                        data_o
);
  always_comb begin
    data_o = '0;
    for (int i = 0; i < N_PIX; i++) begin
      if (addr_i == ADDR_W'(i)) data_o = gray2bin(codes_i[i]);
    end
  end
endmodule

// File: rtl/ssadc_latch_array.sv
module ssadc_latch_array
  import ssadc_pkg::*;
#(
  parameter int N_PIX  = 5,
  parameter int ADDR_W = (N_PIX > 1) ? $clog2(N_PIX) : 1
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               start_i,
  input  logic [N_PIX-1:0]   cmp_i,
  input  logic [ADDR_W-1:0]  rd_addr_i,
  output logic [CODE_W-1:0]  rd_data_o,
  output logic [CODE_W-1:0]  ramp_code_o,
  output logic               busy_o,
  output logic               done_o
);
  logic                        start_acc_w;
  code_t                       ramp_bin_w;
  code_t                       ramp_gray_w;
  logic [N_PIX-1:0]            cmp_sync_w;
  logic [N_PIX-1:0]            load_en_w;
  logic [N_PIX-1:0][CODE_W-1:0] pix_code_w;

  ssadc_ramp_ctr u_ctr (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .start_i     (start_i),
    .start_acc_o (start_acc_w),
    .busy_o      (busy_o),
    .done_o      (done_o),
    .ramp_bin_o  (ramp_bin_w),
    .ramp_gray_o (ramp_gray_w)
  );

  ssadc_cmp_sync #(.N_PIX(N_PIX), .STAGES(2)) u_sync (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .async_i (cmp_i),
    .sync_o  (cmp_sync_w)
  );

  for (genvar p = 0; p < N_PIX; p++) begin : g_pix
    ssadc_pix_cell u_cell (
      .clk_i   (clk_i),
      .rst_ni  (rst_ni),
      .clear_i (start_acc_w),
      .step_i  (busy_o),
      .hit_i   (cmp_sync_w[p]),
      .code_i  (ramp_gray_w),
      .load_o  (load_en_w[p]),
      .code_o  (pix_code_w[p])
    );
  end

  ssadc_readout #(.N_PIX(N_PIX), .ADDR_W(ADDR_W)) u_rd (
    .codes_i (pix_code_w),
    .addr_i  (rd_addr_i),
    .data_o  (rd_data_o)
  );

  assign ramp_code_o = ramp_bin_w;
endmodule

// File: rtl/ssadc_latch_array_chk.sv
module ssadc_latch_array_chk
  import ssadc_pkg::*;
#(
  parameter int N_PIX = 5
) (
  input logic                         clk_i,
  input logic                         rst_ni,
  input logic                         start_i,
  input logic                         busy_o,
  input logic                         done_o,
  input logic [CODE_W-1:0]            ramp_code_o,
  input logic [CODE_W-1:0]            ramp_gray_w,
  input logic [N_PIX-1:0]             load_en_w,
  input logic [N_PIX-1:0][CODE_W-1:0] pix_code_w
);
  a_r2_start_idle: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (start_i && !busy_o) |=> (busy_o && !done_o && ramp_code_o == '0));

  a_r3_ramp_step: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy_o && ramp_code_o != CODE_W'(CODE_MAX)) |=>
      (busy_o && ramp_code_o == $past(ramp_code_o) + CODE_W'(1)));

  a_r3_end_done: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy_o && ramp_code_o == CODE_W'(CODE_MAX) && !start_i) |=> (!busy_o && done_o));

  a_r4_gray_onebit: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy_o && ramp_code_o != CODE_W'(CODE_MAX)) |=>
      ($countones(ramp_gray_w ^ $past(ramp_gray_w)) == 1));

  a_r9_start_busy: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy_o && start_i && ramp_code_o != '0) |=> (ramp_code_o != '0));

  for (genvar p = 0; p < N_PIX; p++) begin : g_hold
    a_r8_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (!load_en_w[p] && !(start_i && !busy_o)) |=> $stable(pix_code_w[p]));
  end
endmodule

bind ssadc_latch_array ssadc_latch_array_chk #(.N_PIX(N_PIX)) chk_i (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .start_i     (start_i),
  .busy_o      (busy_o),
  .done_o      (done_o),
  .ramp_code_o (ramp_code_o),
  .ramp_gray_w (ramp_gray_w),
  .load_en_w   (load_en_w),
  .pix_code_w  (pix_code_w)
);

// File: tb/ssadc_latch_array_tb.sv
module ssadc_latch_array_tb_top;
  localparam int NP = 5;
  localparam int AW = 3;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          start = 1'b0;
  logic [NP-1:0] cmp = '0;
  logic [AW-1:0] rd_addr = '0;
  logic [7:0]    rd_data, ramp;
  logic          busy, done;

  int n_tests = 0;
  int n_fail  = 0;
  int cycles  = 0;

  // behavioural reference state
  int m_busy = 0, m_done = 0, m_ramp = 0;
  int rise_at [NP];

  always #2 clk = ~clk;

  ssadc_latch_array #(.N_PIX(NP), .ADDR_W(AW)) dut_i (
    .clk_i (clk), .rst_ni (rst_n), .start_i (start), .cmp_i (cmp),
    .rd_addr_i (rd_addr), .rd_data_o (rd_data), .ramp_code_o (ramp),
    .busy_o (busy), .done_o (done)
  );

  task automatic check(input string req, input int act, input int exp);
    n_tests++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // reference model: advances on each edge from the inputs present there
  always @(posedge clk) begin
    cycles++;
    if (!rst_n) begin
      m_busy = 0; m_done = 0; m_ramp = 0;
    end else if (start && m_busy == 0) begin
      for (int p = 0; p < NP; p++) rise_at[p] = cmp[p] ? -1 : 1000;
      m_busy = 1; m_done = 0; m_ramp = 0;
    end else if (m_busy == 1) begin
      for (int p = 0; p < NP; p++)
        if (cmp[p] && rise_at[p] == 1000) rise_at[p] = m_ramp;
      if (m_ramp == 255) begin m_busy = 0; m_done = 1; end
      else m_ramp++;
    end
  end

  // per-clock comparison away from the edge (R2, R3, R9)
  always @(negedge clk) begin
    if (rst_n) begin
      check("R3 busy", int'(busy), m_busy);
      check("R3 done", int'(done), m_done);
      check("R2/R3 ramp", int'(ramp), m_ramp);
    end
  end

  function automatic int expect_code(input int r);
    if (r >= 1000) return 255;   // never flipped (R6)
    return (r + 1 > 255) ? 255 : r + 1;
  endfunction

  task automatic read_all(input string req);
    for (int p = 0; p < 8; p++) begin
      @(negedge clk);
      rd_addr = AW'(p);
      #1;
      if (p < NP) check(req, int'(rd_data), expect_code(rise_at[p]));
      else        check("R10 out-of-range", int'(rd_data), 0);
    end
  endtask

  // run one conversion; rise[p] = step index before whose ending edge cmp rises
  task automatic convert(input int rise [NP], input int drop_p, input int drop_e,
                         input int rerise_e, input int extra_start_e);
    @(negedge clk);
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    for (int e = 0; e < 258; e++) begin
      for (int p = 0; p < NP; p++) if (rise[p] == e) cmp[p] = 1'b1;
      if (e == drop_e)   cmp[drop_p] = 1'b0;
      if (e == rerise_e) cmp[drop_p] = 1'b1;
      start = (e == extra_start_e);
      @(negedge clk);
    end
    start = 1'b0;
  endtask

  initial begin : watchdog
    wait (cycles >= 200000);
    n_fail++;
    $display("FAIL watchdog actual=%0d expected<%0d", cycles, 200000);
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    int ra [NP];
    for (int p = 0; p < NP; p++) rise_at[p] = 0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    #1;
    // R1 reset state
    check("R1 busy", int'(busy), 0);
    check("R1 done", int'(done), 0);
    check("R1 ramp", int'(ramp), 0);
    for (int p = 0; p < NP; p++) begin
      rd_addr = AW'(p); #1;
      check("R1 read", int'(rd_data), 0);
    end

    // conversion A: R5, R6, R8, R9, R11; pixel 3 rises before last-but-one edge
    ra = '{10, 100, 5000, 254, 200};
    convert(ra, 4, 220, 230, 50);
    check("R3 done after A", int'(done), 1);
    read_all("R5/R6/R8/R11 conv A");

    // conversion B: R7 (pre-high), step 0, steps 253 and 255, mid value
    cmp = '0;
    @(negedge clk);
    cmp[0] = 1'b1;
    repeat (3) @(negedge clk);
    ra = '{5000, 0, 253, 255, 127};
    convert(ra, 0, 9999, 9999, 9999);
    check("R7 pre-high", int'(rise_at[0]), -1);
    read_all("R5/R7/R10 conv B");

    // conversion C: all never flip -> all 255 (R6), restart straight after done
    cmp = '0;
    ra = '{5000, 5000, 5000, 5000, 5000};
    convert(ra, 0, 9999, 9999, 9999);
    read_all("R6 conv C");

    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule